// File: doc/BRIEF.md
# Authentication Device Command and Mode Controller

This block runs the operating modes of a small authentication device, driven by the bytes it receives over a single-wire serial interface. It keeps one of four modes: communication, computation, programming and thermistor access. In communication mode it reads each received byte as a command. It collects the challenge bytes that must come before every hash computation. It starts the hash engine and blocks further commands until the engine reports done. It then hands the 160-bit result out one byte per read request.

Configuration commands set the secret lock and the bus speed. They act only while an external programming window is open. After one of them the device draws extra current until the next bus reset. The thermistor command pulls the thermistor pin low and makes the device deaf to the bus until the next power-on reset.

Top module: `acm_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (communication). `thm_pull`, `speed_od`, `secret_locked`, `hi_current`, `eng_start` and `tx_valid` are all 0.
- R2: Command 0x0F followed by 8 data bytes loads the challenge. Data byte k (k = 0..7) lands in `chal_data[8k+7:8k]`.
- R3: Command 0x55 with a fresh challenge does three things on the next cycle. It raises `eng_start` for exactly one cycle with `eng_sel` = 0, it sets `mode` to 1 (computation), and it clears `chal_data` to zero.
- R4: A compute command (0x55 or 0x3C) with no complete challenge since the last accepted compute is dropped. `eng_start` stays 0 and `mode` stays 0.
- R5: In computation mode every received byte is ignored. `mode` goes back to 0 on the cycle after `eng_done`.
- R6: After a 0x55 computation ends, each `tx_req` pulse gives `tx_valid` one cycle later. Request k (k = 0..19) returns `eng_digest[8k+7:8k]`. A 21st request gives no `tx_valid`.
- R7: Command 0x3C (next secret) with a fresh challenge starts the engine with `eng_sel` = 1 and leaves nothing to read out. While `secret_locked` is 1, the command is refused without starting the engine and without using up the challenge.
- R8: Commands 0x6A (lock), 0x8B (overdrive on) and 0x8D (overdrive off) act only if `prog_win` is 1 in the cycle the byte arrives. When they act they set `mode` to 2 and `hi_current` to 1, and they update `secret_locked` or `speed_od`. Otherwise they have no effect.
- R9: In programming mode received bytes are ignored. `bus_rst` returns `mode` to 0 and clears `hi_current`; nothing else clears `hi_current`.
- R10: `bus_rst` aborts a challenge still being collected, so the challenge is not fresh. A byte arriving in the same cycle as `bus_rst` is dropped.
- R11: Command 0xA3 sets `thm_pull` to 1 and `mode` to 3 on the next cycle. From then on, bytes, `bus_rst`, `prog_win` and `tx_req` have no effect until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| bus_rst | input | 1 | Bus reset seen on the serial line |
| prog_win | input | 1 | Programming voltage window open |
| tx_req | input | 1 | Host read request for one result byte |
| tx_valid | output | 1 | Result byte valid (one-cycle pulse) |
| tx_byte | output | 8 | Result byte |
| eng_start | output | 1 | One-cycle hash engine start |
| eng_sel | output | 1 | 0 = MAC, 1 = next secret |
| chal_data | output | CHAL_BYTES*8 | Assembled challenge |
| eng_done | input | 1 | Hash engine finished |
| eng_digest | input | RES_BYTES*8 | Hash engine result |
| speed_od | output | 1 | Overdrive bus speed selected |
| secret_locked | output | 1 | Secret lock state |
| hi_current | output | 1 | Programming current state |
| thm_pull | output | 1 | Thermistor pin pull-down enable |
| mode | output | 2 | 0 comm, 1 compute, 2 program, 3 thermistor |

## Verification
Two pairs of events can land in the same cycle.

- **Bus reset and a received byte.** The bench drives `bus_rst` in the same cycle as the fourth challenge byte. It then sends 0x55 and expects no engine start, because the aborted challenge must not count as fresh.
- **Engine completion and read activity.** The bench feeds command bytes, including 0xA3, during computation and expects `mode` to stay at 1 with `thm_pull` low. It then pulses `eng_done` and checks that the mode drops to 0 exactly one cycle later. A compute issued straight afterwards must be refused, because the challenge was consumed.

// File: rtl/acm_pkg.sv
package acm_pkg;

    typedef enum logic [1:0] {
        MD_COMM  = 2'd0,
        MD_COMP  = 2'd1,
        MD_PROG  = 2'd2,
        MD_THERM = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_WRCHAL,
        CK_MAC,
        CK_NEXT,
        CK_LOCK,
        CK_ODSET,
        CK_ODCLR,
        CK_THERM
    } cmd_e;

    localparam logic [7:0] OP_WRCHAL = 8'h0F;
    localparam logic [7:0] OP_MAC    = 8'h55;
    localparam logic [7:0] OP_NEXT   = 8'h3C;
    localparam logic [7:0] OP_LOCK   = 8'h6A;
    localparam logic [7:0] OP_ODSET  = 8'h8B;
    localparam logic [7:0] OP_ODCLR  = 8'h8D;
    localparam logic [7:0] OP_THERM  = 8'hA3;

    typedef struct packed {
        mode_e mode;
        logic  start;
        logic  sel;
        logic  locked;
        logic  od;
        logic  hi_cur;
    } ctl_t;

endpackage

// File: rtl/acm_decode.sv
module acm_decode
    import acm_pkg::*;
(
    input  logic [7:0] code,
    output cmd_e       kind
);

    always_comb begin
        unique case (code)
            OP_WRCHAL: kind = CK_WRCHAL;
            OP_MAC:    kind = CK_MAC;
            OP_NEXT:   kind = CK_NEXT;
            OP_LOCK:   kind = CK_LOCK;
            OP_ODSET:  kind = CK_ODSET;
            OP_ODCLR:  kind = CK_ODCLR;
            OP_THERM:  kind = CK_THERM;
            default:   kind = CK_NONE;
        endcase
    end

endmodule

// File: rtl/acm_chal.sv
module acm_chal #(
    parameter int BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               byte_v,
    input  logic [7:0]         byte_in,
    input  logic               abort,
    input  logic               consume,
    output logic               collecting,
    output logic               fresh,
    output logic [BYTES*8-1:0] data
);

    localparam int IW = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [IW-1:0] LAST = IW'(BYTES - 1);

    typedef struct packed {
        logic               coll;
        logic               fresh;
        logic [IW-1:0]      cnt;
        logic [BYTES*8-1:0] data;
    } chal_t;

    chal_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d.coll = 1'b0;
            s_d.cnt  = '0;
        end else if (start) begin
            s_d.coll  = 1'b1;
            s_d.cnt   = '0;
            s_d.fresh = 1'b0;
            s_d.data  = '0;
        end else if (byte_v && s_q.coll) begin
            s_d.data[s_q.cnt*8 +: 8] = byte_in;
            if (s_q.cnt == LAST) begin
                s_d.coll  = 1'b0;
                s_d.fresh = 1'b1;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (consume) begin
            s_d.fresh = 1'b0;
            s_d.data  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign collecting = s_q.coll;
    assign fresh      = s_q.fresh;
    assign data       = s_q.data;

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(abort) |-> !s_q.coll);

    // R2
    fresh_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.fresh) |-> $past(s_q.coll) && $past(byte_v));

endmodule

// File: rtl/acm_result.sv
module acm_result #(
    parameter int BYTES = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BYTES*8-1:0] digest,
    input  logic               drop,
    input  logic               req,
    output logic               tx_valid,
    output logic [7:0]         tx_byte
);

    localparam int IW = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [IW-1:0] LAST = IW'(BYTES - 1);

    typedef struct packed {
        logic               avail;
        logic [IW-1:0]      idx;
        logic [BYTES*8-1:0] data;
        logic               v;
        logic [7:0]         b;
    } res_t;

    res_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        s_d.v = 1'b0;
        if (load) begin
            s_d.avail = 1'b1;
            s_d.idx   = '0;
            s_d.data  = digest;
        end else if (drop) begin
            s_d.avail = 1'b0;
            s_d.idx   = '0;
        end else if (req && s_q.avail) begin
            s_d.v = 1'b1;
            s_d.b = s_q.data[s_q.idx*8 +: 8];
            if (s_q.idx == LAST) begin
                s_d.avail = 1'b0;
                s_d.idx   = '0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_valid = s_q.v;
    assign tx_byte  = s_q.b;

    // R6
    tx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.v |-> $past(req) && $past(s_q.avail));

endmodule

// File: rtl/acm_mode_ctrl.sv
module acm_mode_ctrl
    import acm_pkg::*;
#(
    parameter int CHAL_BYTES = 8,
    parameter int RES_BYTES  = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    input  logic                    bus_rst,
    input  logic                    prog_win,
    input  logic                    tx_req,
    output logic                    tx_valid,
    output logic [7:0]              tx_byte,
    output logic                    eng_start,
    output logic                    eng_sel,
    output logic [CHAL_BYTES*8-1:0] chal_data,
    input  logic                    eng_done,
    input  logic [RES_BYTES*8-1:0]  eng_digest,
    output logic                    speed_od,
    output logic                    secret_locked,
    output logic                    hi_current,
    output logic                    thm_pull,
    output logic [1:0]              mode
);

    ctl_t c_d, c_q;
    cmd_e kind;

    logic chal_start, chal_bv, chal_abort, chal_consume;
    logic chal_coll, chal_fresh;
    logic res_load, res_drop, res_req;

    acm_decode u_dec (
        .code (rx_byte),
        .kind (kind)
    );

    always_comb begin
        c_d          = c_q;
        c_d.start    = 1'b0;
        chal_start   = 1'b0;
        chal_bv      = 1'b0;
        chal_abort   = 1'b0;
        chal_consume = 1'b0;
        res_load     = 1'b0;
        res_drop     = 1'b0;
        res_req      = 1'b0;
        if (c_q.mode != MD_THERM) begin
            if (bus_rst) begin
                chal_abort = 1'b1;
                c_d.hi_cur = 1'b0;
                if (c_q.mode == MD_PROG) c_d.mode = MD_COMM;
                if (c_q.mode == MD_COMP && eng_done) begin
                    c_d.mode = MD_COMM;
                    res_load = !c_q.sel;
                end
            end else begin
                unique case (c_q.mode)
                    MD_COMM: begin
                        res_req = tx_req;
                        if (rx_valid && chal_coll) begin
                            chal_bv = 1'b1;
                        end else if (rx_valid) begin
                            unique case (kind)
                                CK_WRCHAL: chal_start = 1'b1;
                                CK_MAC, CK_NEXT: begin
                                    if (chal_fresh &&
                                        !(kind == CK_NEXT && c_q.locked)) begin
                                        c_d.start    = 1'b1;
                                        c_d.sel      = (kind == CK_NEXT);
                                        c_d.mode     = MD_COMP;
                                        chal_consume = 1'b1;
                                        res_drop     = 1'b1;
                                    end
                                end
                                CK_LOCK, CK_ODSET, CK_ODCLR: begin
                                    if (prog_win) begin
                                        c_d.mode   = MD_PROG;
                                        c_d.hi_cur = 1'b1;
                                        if (kind == CK_LOCK)  c_d.locked = 1'b1;
                                        if (kind == CK_ODSET) c_d.od     = 1'b1;
                                        if (kind == CK_ODCLR) c_d.od     = 1'b0;
                                    end
                                end
                                CK_THERM: c_d.mode = MD_THERM;
                                default: ;
                            endcase
                        end
                    end
                    MD_COMP: begin
                        if (eng_done) begin
                            c_d.mode = MD_COMM;
                            res_load = !c_q.sel;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{mode: MD_COMM, default: '0};
        else        c_q <= c_d;
    end

    acm_chal #(.BYTES(CHAL_BYTES)) u_chal (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (chal_start),
        .byte_v     (chal_bv),
        .byte_in    (rx_byte),
        .abort      (chal_abort),
        .consume    (chal_consume),
        .collecting (chal_coll),
        .fresh      (chal_fresh),
        .data       (chal_data)
    );

    acm_result #(.BYTES(RES_BYTES)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (res_load),
        .digest   (eng_digest),
        .drop     (res_drop),
        .req      (res_req),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    assign eng_start     = c_q.start;
    assign eng_sel       = c_q.sel;
    assign speed_od      = c_q.od;
    assign secret_locked = c_q.locked;
    assign hi_current    = c_q.hi_cur;
    assign thm_pull      = (c_q.mode == MD_THERM);
    assign mode          = c_q.mode;

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.start |=> !c_q.start);

    // R4
    start_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.start |-> $past(chal_fresh));

    // R5
    comp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.mode == MD_COMP && !eng_done) |=> c_q.mode == MD_COMP);

    // R8
    od_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_q.od) |-> $past(prog_win));

    // R9
    hicur_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.hi_cur) |-> $past(bus_rst));

    // R11
    therm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.mode == MD_THERM |=> c_q.mode == MD_THERM);

endmodule

// File: tb/sim_acm_mode_ctrl.sv
module sim_acm_mode_ctrl;

    localparam int CB = 8;
    localparam int RB = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic bus_rst = 1'b0;
    logic prog_win = 1'b0;
    logic tx_req = 1'b0;
    logic eng_done = 1'b0;
    logic [RB*8-1:0] eng_digest = '0;
    logic tx_valid, eng_start, eng_sel, speed_od, secret_locked, hi_current, thm_pull;
    logic [7:0] tx_byte;
    logic [CB*8-1:0] chal_data;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    acm_mode_ctrl #(.CHAL_BYTES(CB), .RES_BYTES(RB)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .bus_rst(bus_rst), .prog_win(prog_win), .tx_req(tx_req),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .eng_start(eng_start),
        .eng_sel(eng_sel), .chal_data(chal_data), .eng_done(eng_done),
        .eng_digest(eng_digest), .speed_od(speed_od),
        .secret_locked(secret_locked), .hi_current(hi_current),
        .thm_pull(thm_pull), .mode(mode)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic brst();
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic wr_chal(input int seed);
        send(8'h0F);
        for (int k = 0; k < CB; k++) send(8'((k * 19 + seed) & 255));
    endtask

    initial begin
        logic [CB*8-1:0] exp_ch;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 mode", 64'(mode), 64'd0);
        chk("R1 outs", {58'd0, thm_pull, speed_od, secret_locked, hi_current, eng_start, tx_valid}, 64'd0);

        // R4 compute with no challenge
        send(8'h55);
        chk("R4 start", 64'(eng_start), 64'd0);
        chk("R4 mode", 64'(mode), 64'd0);

        // R8 sweep every byte without programming window
        for (int b = 0; b < 256; b++) begin
            if (b != 8'hA3) begin
                send(8'(b));
                chk("R8 sweep mode", 64'(mode), 64'd0);
                chk("R8 sweep cfg", {61'd0, speed_od, secret_locked, eng_start}, 64'd0);
                brst();
            end
        end

        // R2 challenge assembly
        wr_chal(3);
        exp_ch = '0;
        for (int k = 0; k < CB; k++) exp_ch[k*8 +: 8] = 8'((k * 19 + 3) & 255);
        chk("R2 chal", 64'(chal_data), 64'(exp_ch));

        // R10 bus reset in same cycle as a challenge byte
        send(8'h0F);
        send(8'h11); send(8'h22); send(8'h33);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h44; bus_rst = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; bus_rst = 1'b0;
        send(8'h55);
        chk("R10 no start", 64'(eng_start), 64'd0);
        chk("R10 mode", 64'(mode), 64'd0);

        // R3 compute MAC
        wr_chal(7);
        send(8'h55);
        chk("R3 start", {62'd0, eng_start, eng_sel}, 64'd2);
        chk("R3 mode", 64'(mode), 64'd1);
        chk("R3 chal cleared", 64'(chal_data), 64'd0);
        @(negedge clk);
        chk("R3 pulse", 64'(eng_start), 64'd0);

        // R5 bytes ignored during computation
        send(8'h0F); send(8'hA3); send(8'h8B);
        chk("R5 mode", 64'(mode), 64'd1);
        chk("R5 thm", 64'(thm_pull), 64'd0);
        for (int k = 0; k < RB; k++) eng_digest[k*8 +: 8] = 8'((k * 37 + 11) & 255);
        done_pulse();
        chk("R5 back", 64'(mode), 64'd0);
        send(8'h55);
        chk("R4 consumed", 64'(eng_start), 64'd0);

        // R6 readout
        for (int k = 0; k < RB; k++) begin
            rd();
            chk("R6 valid", 64'(tx_valid), 64'd1);
            chk("R6 byte", 64'(tx_byte), 64'((k * 37 + 11) & 255));
        end
        rd();
        chk("R6 past end", 64'(tx_valid), 64'd0);

        // R7 next secret
        wr_chal(5);
        send(8'h3C);
        chk("R7 start", {62'd0, eng_start, eng_sel}, 64'd3);
        done_pulse();
        chk("R7 mode", 64'(mode), 64'd0);
        rd();
        chk("R7 no result", 64'(tx_valid), 64'd0);

        // R8 configuration with window, R9 programming mode
        prog_win = 1'b1;
        send(8'h8B);
        chk("R8 prog mode", 64'(mode), 64'd2);
        chk("R8 od hi", {62'd0, speed_od, hi_current}, 64'd3);
        send(8'h8D);
        chk("R9 ignored", 64'(speed_od), 64'd1);
        brst();
        chk("R9 mode", 64'(mode), 64'd0);
        chk("R9 hicur", 64'(hi_current), 64'd0);
        send(8'h8D);
        chk("R8 od clr", 64'(speed_od), 64'd0);
        brst();
        prog_win = 1'b0;
        send(8'h8B);
        chk("R8 no window", {62'd0, speed_od, hi_current}, 64'd0);
        prog_win = 1'b1;
        send(8'h6A);
        chk("R8 lock", 64'(secret_locked), 64'd1);
        brst();
        prog_win = 1'b0;

        // R7 refused when locked, challenge kept
        wr_chal(9);
        send(8'h3C);
        chk("R7 locked", {62'd0, eng_start, mode == 2'd0}, 64'd1);
        send(8'h55);
        chk("R7 chal kept", 64'(eng_start), 64'd1);
        done_pulse();

        // R11 thermistor mode
        send(8'hA3);
        chk("R11 thm", {61'd0, thm_pull, mode}, 64'd7);
        send(8'h0F);
        brst();
        prog_win = 1'b1;
        send(8'h8D);
        prog_win = 1'b0;
        rd();
        chk("R11 sticky", {61'd0, thm_pull, mode}, 64'd7);
        chk("R11 ignored", {61'd0, speed_od, hi_current, tx_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 released", {61'd0, thm_pull, mode}, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule